// File: doc/BRIEF.md
# Variable-Length Full-Duplex UART

This block is an asynchronous serial transceiver whose transmitter and receiver run independently and at the same time. Both take their timing from one shared programmable rate generator. A frame carries 7, 8 or 9 data bits, sent least-significant bit first, with no parity. The frame opens with a low start bit and closes with a high stop bit.

The transmitter works from a one-word holding register, which software loads through the register port. In single-frame mode every frame ends with one stop bit. In continuous mode, when a further word is already waiting at the end of a frame, a second stop bit is inserted and the next frame follows with no other gap.

The receiver watches for a falling edge on the idle-high line. It confirms the start bit at its centre and then samples every later bit at its centre. A stop bit sampled low is reported as a framing error, and the word is still handed over.

Top module: `uartv_top`

## Requirements
- R1: Reset state. While reset is held and just after it, `txd` is 1, `txEmpty` is 1, `rxFull` is 0 and `rxFrameErr` is 0.
- R2: Transmit frame format. A transmitted frame is a 0 start bit, then the data bits of the holding register least-significant bit first, then a 1 stop bit. The data-length code sets the number of data bits: 0 gives 7 bits, 1 gives 8 bits, and 2 or 3 give 9 bits.
- R3: Bit period. Every bit on `txd` lasts exactly 16*(D+1) clock cycles, where D is the divisor register.
- R4: Register map. Address 0 is the data register: a write loads the transmit holding register, and a read returns the last received word right-aligned and zero-extended. Address 1 is control: bits [1:0] hold the length code and bit 2 is continuous enable; reads return the same value. Address 2 is the divisor D. Address 3 reads as 0.
- R5: `txEmpty` drops in the cycle after a write to address 0. It rises when the holding word moves into the transmit shifter. With D=0 and an idle transmitter, that happens one cycle later, and `txd` goes low in that same cycle.
- R6: In single-frame mode, a word that waits in the holding register starts only after the previous frame's single stop bit. That stop bit has ended and a further D+1 cycles have passed.
- R7: In continuous mode, when the holding register is full at the end of the first stop bit, the line stays high for exactly two bit periods before the next start bit.
- R8: In continuous mode, when the holding register is empty at the end of the first stop bit, the transmitter goes idle after that one stop bit. `txd` then stays high.
- R9: The receiver re-samples the line at the middle of the start bit. A low pulse shorter than half a bit is discarded, and `rxFull` does not rise.
- R10: Receiving a word. The received bits are assembled least-significant bit first, and `rxFull` rises at the middle of the stop bit. A read strobe on address 0 clears `rxFull`. When a read strobe and a frame completion fall in the same cycle, `rxFull` is set.
- R11: A stop bit sampled low sets `rxFrameErr` and still delivers the word and sets `rxFull`. A later frame with a good stop bit clears `rxFrameErr`.
- R12: A frame can be transmitted and a different frame received over the same interval, and both are correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Read strobe; on address 0 it clears `rxFull` |
| regAddr | input | 2 | Register address |
| regWdata | input | REG_W | Write data |
| regRdata | output | REG_W | Read data for `regAddr` (combinational) |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| txEmpty | output | 1 | Transmit holding register is empty |
| rxFull | output | 1 | A received word is waiting |
| rxFrameErr | output | 1 | The last received stop bit was low |

## Verification
The one collision that matters is a read strobe on the data register landing in the same cycle as a frame completion. One acts on `rxFull` by clearing it and the other by setting it. The bench holds the read strobe high for the whole of an incoming frame, which forces that coincidence. It then expects `rxFull` to be seen high for exactly one cycle: the set wins, and the next strobe clears it. A clear-wins design never shows the flag. Transmit and receive also run side by side with different words, so the shared rate generator must serve both paths at once.

// File: rtl/uartv_pkg.sv
package uartv_pkg;
  localparam int DATA_MAX = 9;
  localparam int OVS = 16;
  localparam int SUB_W = $clog2(OVS);
  localparam int HALF = OVS / 2;
  localparam int BIT_W = $clog2(DATA_MAX + 1);

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_DIV  = 2'd2;

  typedef enum logic [1:0] {LVL_MARK, LVL_SPACE, LVL_DATA} txLevel_t;

  typedef struct packed {
    logic       txLoad;
    logic       txShift;
    logic       rxShift;
    logic       rxCommit;
    logic       rxBit;
    logic [1:0] rxLen;
    txLevel_t   txLevel;
  } strobe_t;

  function automatic logic [BIT_W-1:0] lenBits(input logic [1:0] code);
    case (code)
      2'd0:    lenBits = BIT_W'(7);
      2'd1:    lenBits = BIT_W'(8);
      default: lenBits = BIT_W'(9);
    endcase
  endfunction
endpackage

// File: rtl/uartv_ctrl.sv
module uartv_ctrl
  import uartv_pkg::*;
#(
  parameter int DIV_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxd,
  input  logic             holdValid,
  input  logic [1:0]       cfgLen,
  input  logic             cfgCont,
  input  logic [DIV_W-1:0] cfgDiv,
  output strobe_t          strb
);
  typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP, TX_STOP2} txState_t;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rxState_t;

  // shared rate generator: one tick every cfgDiv+1 cycles
  logic [DIV_W-1:0] divCnt;
  logic tick;
  assign tick = (divCnt == cfgDiv);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= tick ? '0 : divCnt + DIV_W'(1);
  end

  // ---------------- transmit sequencer ----------------
  txState_t         txState;
  logic [SUB_W-1:0] txSub;
  logic [BIT_W-1:0] txBitCnt;
  logic [BIT_W-1:0] txLenQ;
  logic txBitEnd, txLoadIdle, txLoadCont, txLastBit;

  assign txBitEnd   = tick && (txSub == SUB_W'(OVS - 1));
  assign txLoadIdle = (txState == TX_IDLE) && holdValid && tick;
  assign txLoadCont = (txState == TX_STOP) && txBitEnd && cfgCont && holdValid;
  assign txLastBit  = (txBitCnt == txLenQ - BIT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState  <= TX_IDLE;
      txSub    <= '0;
      txBitCnt <= '0;
      txLenQ   <= BIT_W'(8);
    end else if (txState == TX_IDLE) begin
      if (txLoadIdle) begin
        txState  <= TX_START;
        txSub    <= '0;
        txBitCnt <= '0;
        txLenQ   <= lenBits(cfgLen);
      end
    end else begin
      if (tick) txSub <= txSub + SUB_W'(1);
      if (txBitEnd) begin
        case (txState)
          TX_START: begin
            txState  <= TX_DATA;
            txBitCnt <= '0;
          end
          TX_DATA: begin
            if (txLastBit) txState <= TX_STOP;
            else           txBitCnt <= txBitCnt + BIT_W'(1);
          end
          TX_STOP: begin
            if (txLoadCont) begin
              txState <= TX_STOP2;
              txLenQ  <= lenBits(cfgLen);
            end else begin
              txState <= TX_IDLE;
            end
          end
          TX_STOP2: begin
            txState  <= TX_START;
            txBitCnt <= '0;
          end
          default: txState <= TX_IDLE;
        endcase
      end
    end
  end

  // ---------------- receive sequencer ----------------
  rxState_t         rxState;
  logic [1:0]       rxSync;
  logic             rxIn, rxPrev;
  logic [SUB_W-1:0] rxSub;
  logic [BIT_W-1:0] rxBitCnt;
  logic [1:0]       rxLenQ;
  logic rxBitEnd, rxMidStart;

  assign rxIn       = rxSync[1];
  assign rxBitEnd   = tick && (rxSub == SUB_W'(OVS - 1));
  assign rxMidStart = tick && (rxSub == SUB_W'(HALF - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSync <= 2'b11;
      rxPrev <= 1'b1;
    end else begin
      rxSync <= {rxSync[0], rxd};
      rxPrev <= rxIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState  <= RX_IDLE;
      rxSub    <= '0;
      rxBitCnt <= '0;
      rxLenQ   <= 2'd1;
    end else begin
      case (rxState)
        RX_IDLE: begin
          if (rxPrev && !rxIn) begin
            rxState <= RX_START;
            rxSub   <= '0;
            rxLenQ  <= cfgLen;
          end
        end
        RX_START: begin
          if (rxMidStart) begin
            rxSub <= '0;
            if (!rxIn) begin
              rxState  <= RX_DATA;
              rxBitCnt <= '0;
            end else begin
              rxState <= RX_IDLE;
            end
          end else if (tick) begin
            rxSub <= rxSub + SUB_W'(1);
          end
        end
        RX_DATA: begin
          if (tick) rxSub <= rxSub + SUB_W'(1);
          if (rxBitEnd) begin
            if (rxBitCnt == lenBits(rxLenQ) - BIT_W'(1)) rxState <= RX_STOP;
            else rxBitCnt <= rxBitCnt + BIT_W'(1);
          end
        end
        RX_STOP: begin
          if (tick) rxSub <= rxSub + SUB_W'(1);
          if (rxBitEnd) rxState <= RX_IDLE;
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.txLoad   = txLoadIdle || txLoadCont;
    strb.txShift  = (txState == TX_DATA) && txBitEnd;
    strb.rxShift  = (rxState == RX_DATA) && rxBitEnd;
    strb.rxCommit = (rxState == RX_STOP) && rxBitEnd;
    strb.rxBit    = rxIn;
    strb.rxLen    = rxLenQ;
    case (txState)
      TX_START: strb.txLevel = LVL_SPACE;
      TX_DATA:  strb.txLevel = LVL_DATA;
      default:  strb.txLevel = LVL_MARK;
    endcase
  end

  // bit timing only advances on a rate tick
  assert_sub_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && txState != TX_IDLE) |=> $stable(txSub));
  // data bit index stays inside the latched length
  assert_bitcnt_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    (txState == TX_DATA) |-> (txBitCnt < txLenQ));
  // second stop bit only when continuous and a word was waiting
  assert_stop2_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txState == TX_STOP2) |-> ($past(cfgCont) && $past(holdValid)));
  // start qualification happens by half a bit
  assert_start_window_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == RX_START) |-> (rxSub < SUB_W'(HALF)));
  // after delivery the receiver waits for a new edge
  assert_commit_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.rxCommit |=> (rxState == RX_IDLE));
endmodule

// File: rtl/uartv_dp.sv
module uartv_dp
  import uartv_pkg::*;
#(
  parameter int DIV_W = 9,
  parameter int REG_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic             regRe,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWdata,
  input  strobe_t          strb,
  output logic [REG_W-1:0] regRdata,
  output logic             txd,
  output logic             txEmpty,
  output logic             rxFull,
  output logic             rxFrameErr,
  output logic             holdValid,
  output logic [1:0]       cfgLen,
  output logic             cfgCont,
  output logic [DIV_W-1:0] cfgDiv
);
  logic [DATA_MAX-1:0] holdReg, txSh, rxSh, rxData;
  logic wrData, rdData;

  assign wrData = regWe && (regAddr == ADDR_DATA);
  assign rdData = regRe && (regAddr == ADDR_DATA);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgLen  <= 2'd1;
      cfgCont <= 1'b0;
      cfgDiv  <= '0;
    end else if (regWe) begin
      if (regAddr == ADDR_CTRL) begin
        cfgLen  <= regWdata[1:0];
        cfgCont <= regWdata[2];
      end
      if (regAddr == ADDR_DIV) cfgDiv <= regWdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg   <= '0;
      holdValid <= 1'b0;
    end else if (wrData) begin
      holdReg   <= regWdata[DATA_MAX-1:0];
      holdValid <= 1'b1;
    end else if (strb.txLoad) begin
      holdValid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             txSh <= '0;
    else if (strb.txLoad)  txSh <= holdReg;
    else if (strb.txShift) txSh <= txSh >> 1;
  end

  always_comb begin
    case (strb.txLevel)
      LVL_SPACE: txd = 1'b0;
      LVL_DATA:  txd = txSh[0];
      default:   txd = 1'b1;
    endcase
  end

  assign txEmpty = !holdValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rxSh <= '0;
    else if (strb.rxShift) rxSh <= {strb.rxBit, rxSh[DATA_MAX-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData     <= '0;
      rxFull     <= 1'b0;
      rxFrameErr <= 1'b0;
    end else if (strb.rxCommit) begin
      case (strb.rxLen)
        2'd0:    rxData <= rxSh >> 2;
        2'd1:    rxData <= rxSh >> 1;
        default: rxData <= rxSh;
      endcase
      rxFull     <= 1'b1;
      rxFrameErr <= !strb.rxBit;
    end else if (rdData) begin
      rxFull <= 1'b0;
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_DATA: regRdata = REG_W'(rxData);
      ADDR_CTRL: regRdata = REG_W'({cfgCont, cfgLen});
      ADDR_DIV:  regRdata = REG_W'(cfgDiv);
      default:   regRdata = '0;
    endcase
  end

  assert_write_fills_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrData |=> !txEmpty);
  assert_commit_sets_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.rxCommit |=> rxFull);
  assert_full_needs_commit_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) |-> $past(strb.rxCommit));
  always_comb begin
    if (rstN) assert_load_shift_excl_R2: assert (!(strb.txLoad && strb.txShift));
  end
endmodule

// File: rtl/uartv_top.sv
module uartv_top
  import uartv_pkg::*;
#(
  parameter int DIV_W = 9,
  localparam int REG_W = (DIV_W > DATA_MAX) ? DIV_W : DATA_MAX
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic             regRe,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] regRdata,
  input  logic             rxd,
  output logic             txd,
  output logic             txEmpty,
  output logic             rxFull,
  output logic             rxFrameErr
);
  strobe_t          strb;
  logic             holdValid;
  logic [1:0]       cfgLen;
  logic             cfgCont;
  logic [DIV_W-1:0] cfgDiv;

  uartv_ctrl #(.DIV_W(DIV_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .rxd(rxd), .holdValid(holdValid),
    .cfgLen(cfgLen), .cfgCont(cfgCont), .cfgDiv(cfgDiv), .strb(strb)
  );

  uartv_dp #(.DIV_W(DIV_W), .REG_W(REG_W)) dp_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .strb(strb), .regRdata(regRdata), .txd(txd),
    .txEmpty(txEmpty), .rxFull(rxFull), .rxFrameErr(rxFrameErr),
    .holdValid(holdValid), .cfgLen(cfgLen), .cfgCont(cfgCont), .cfgDiv(cfgDiv)
  );
endmodule

// File: tb/uartv_top_tb_top.sv
module uartv_top_tb_top;
  localparam int REG_W = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0, regRe = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [REG_W-1:0] regWdata = '0;
  logic [REG_W-1:0] regRdata;
  logic txd, txEmpty, rxFull, rxFrameErr;
  logic loopBack = 1'b0, drvRx = 1'b1;
  logic rxdW;
  assign rxdW = loopBack ? txd : drvRx;

  always #5 clk = ~clk;

  uartv_top #(.DIV_W(9)) dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .rxd(rxdW), .txd(txd),
    .txEmpty(txEmpty), .rxFull(rxFull), .rxFrameErr(rxFrameErr)
  );

  int nTests = 0, nFail = 0, cyc = 0;
  int P = 16, HP = 8, curDiv = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int nb(input int len);
    return (len == 0) ? 7 : (len == 1) ? 8 : 9;
  endfunction

  task automatic regWrite(input int a, input int d);
    @(negedge clk);
    regWe = 1'b1; regAddr = 2'(a); regWdata = REG_W'(d);
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input int a, output int v);
    @(negedge clk);
    regAddr = 2'(a);
    #1 v = int'(regRdata);
  endtask

  task automatic rxClear();
    @(negedge clk);
    regAddr = 2'd0; regRe = 1'b1;
    @(negedge clk);
    regRe = 1'b0;
  endtask

  task automatic setCfg(input int len, input int cont, input int div);
    regWrite(2, div);
    regWrite(1, (cont << 2) | len);
    curDiv = div; P = 16 * (div + 1); HP = P / 2;
    repeat (520) @(negedge clk);
  endtask

  task automatic waitStart();
    @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
  endtask

  // called at the first negedge inside a start bit
  task automatic sampleFrame(input int n, output int w, output bit startOk, output bit stopOk);
    repeat (HP) @(negedge clk);
    startOk = (txd == 1'b0);
    w = 0;
    for (int i = 0; i < n; i++) begin
      repeat (P) @(negedge clk);
      w |= int'(txd) << i;
    end
    repeat (P) @(negedge clk);
    stopOk = (txd == 1'b1);
  endtask

  task automatic driveRx(input int word, input int n, input bit stopLvl);
    @(negedge clk);
    drvRx = 1'b0;
    repeat (P) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      drvRx = word[i];
      repeat (P) @(negedge clk);
    end
    drvRx = stopLvl;
    repeat (P) @(negedge clk);
    drvRx = 1'b1;
    repeat (P) @(negedge clk);
  endtask

  task automatic highRun(output int c);
    c = 0;
    @(negedge clk);
    while (txd == 1'b1 && c < 100000) begin
      c++;
      @(negedge clk);
    end
  endtask

  initial begin
    int v, w, w2, c, exp, hiCnt;
    bit sOk, pOk, s2, p2;

    // R1 reset state
    repeat (4) @(negedge clk);
    chk(txd == 1'b1 && txEmpty == 1'b1, "R1 txd/txEmpty in reset", {txd, txEmpty}, 3);
    chk(rxFull == 1'b0 && rxFrameErr == 1'b0, "R1 rx flags in reset", {rxFull, rxFrameErr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1 && txEmpty == 1'b1 && rxFull == 1'b0, "R1 after release",
        {txd, txEmpty, rxFull}, 6);

    // R4 register map
    setCfg(2, 1, 3);
    regRead(1, v); chk(v == 6, "R4 control readback", v, 6);
    regRead(2, v); chk(v == 3, "R4 divisor readback", v, 3);
    regRead(3, v); chk(v == 0, "R4 unused address", v, 0);

    // R5 / R3 exact timing with D=0
    setCfg(1, 0, 0);
    regWrite(0, 9'h05B);
    chk(txEmpty == 1'b0, "R5 txEmpty drops after write", txEmpty, 0);
    @(negedge clk);
    chk(txEmpty == 1'b1 && txd == 1'b0, "R5 transfer and start same cycle", {txEmpty, txd}, 2);
    c = 1;
    @(negedge clk);
    while (txd == 1'b0) begin c++; @(negedge clk); end
    chk(c == P, "R3 start bit length D=0", c, P);
    repeat (12 * P) @(negedge clk);

    setCfg(1, 0, 2);
    regWrite(0, 9'h0E1);
    waitStart();
    c = 1;
    @(negedge clk);
    while (txd == 1'b0) begin c++; @(negedge clk); end
    chk(c == 48, "R3 start bit length D=2", c, 48);
    repeat (12 * P) @(negedge clk);

    // R2 / R10 sweep in loopback over divisors, lengths and words
    loopBack = 1'b1;
    for (int d = 0; d < 2; d++) begin
      for (int len = 0; len < 4; len++) begin
        setCfg(len, 0, d);
        for (int k = 0; k < 4; k++) begin
          int data, mask;
          data = (k * 211 + len * 90 + 165 + d * 77) & 511;
          mask = (1 << nb(len)) - 1;
          regWrite(0, data);
          waitStart();
          sampleFrame(nb(len), w, sOk, pOk);
          chk(sOk && pOk, "R2 start and stop levels", {sOk, pOk}, 3);
          chk(w == (data & mask), "R2 data bits LSB first", w, data & mask);
          repeat (P) @(negedge clk);
          chk(rxFull == 1'b1, "R10 rxFull after frame", rxFull, 1);
          regRead(0, v);
          chk(v == (data & mask), "R10 received word", v, data & mask);
          chk(rxFrameErr == 1'b0, "R11 no framing error", rxFrameErr, 0);
          rxClear();
          chk(rxFull == 1'b0, "R10 read clears rxFull", rxFull, 1'b0);
        end
      end
    end
    loopBack = 1'b0;

    // R6 single mode back-to-back
    setCfg(1, 0, 1);
    fork
      begin
        waitStart();
        sampleFrame(8, w, sOk, pOk);
        highRun(c);
        sampleFrame(8, w2, s2, p2);
      end
      begin
        regWrite(0, 9'h0C3);
        while (txEmpty == 1'b0) @(negedge clk);
        regWrite(0, 9'h03A);
      end
    join
    exp = P + curDiv + 1 - 1 - HP;
    chk(c == exp, "R6 single-mode gap", c, exp);
    chk(w == 9'h0C3 && w2 == 9'h03A, "R6 both frames intact", w2, 9'h03A);

    // R7 continuous mode two stop bits
    setCfg(1, 1, 1);
    fork
      begin
        waitStart();
        sampleFrame(8, w, sOk, pOk);
        highRun(c);
        sampleFrame(8, w2, s2, p2);
      end
      begin
        regWrite(0, 9'h096);
        while (txEmpty == 1'b0) @(negedge clk);
        regWrite(0, 9'h069);
      end
    join
    exp = 2 * P - 1 - HP;
    chk(c == exp, "R7 continuous gap two stop bits", c, exp);
    chk(w == 9'h096 && w2 == 9'h069, "R7 both frames intact", w2, 9'h069);
    repeat (2 * P) @(negedge clk);

    // R8 continuous with empty holding register
    regWrite(0, 9'h0F0);
    waitStart();
    sampleFrame(8, w, sOk, pOk);
    c = 0;
    repeat (3 * P) begin
      @(negedge clk);
      if (txd == 1'b0) c++;
    end
    chk(c == 0, "R8 line stays idle", c, 0);
    chk(txEmpty == 1'b1, "R8 txEmpty still set", txEmpty, 1);

    // R9 glitch rejection
    setCfg(1, 0, 0);
    @(negedge clk);
    drvRx = 1'b0;
    repeat (HP / 2) @(negedge clk);
    drvRx = 1'b1;
    repeat (3 * P) @(negedge clk);
    chk(rxFull == 1'b0, "R9 short low pulse ignored", rxFull, 0);
    driveRx(9'h03C, 8, 1'b1);
    regRead(0, v);
    chk(rxFull == 1'b1 && v == 9'h03C, "R9 frame after glitch", v, 9'h03C);
    rxClear();

    // R11 framing error
    driveRx(9'h0B5, 8, 1'b0);
    chk(rxFrameErr == 1'b1, "R11 bad stop flagged", rxFrameErr, 1);
    regRead(0, v);
    chk(rxFull == 1'b1 && v == 9'h0B5, "R11 word still delivered", v, 9'h0B5);
    rxClear();
    driveRx(9'h011, 8, 1'b1);
    chk(rxFrameErr == 1'b0, "R11 good stop clears flag", rxFrameErr, 0);
    rxClear();

    // R10 read strobe colliding with frame completion
    regAddr = 2'd0;
    regRe = 1'b1;
    hiCnt = 0;
    fork
      driveRx(9'h0A7, 8, 1'b1);
      repeat (11 * P) begin
        @(negedge clk);
        if (rxFull) hiCnt++;
      end
    join
    regRe = 1'b0;
    chk(hiCnt == 1, "R10 set wins over same-cycle read", hiCnt, 1);
    regRead(0, v);
    chk(v == 9'h0A7, "R10 word after collision", v, 9'h0A7);

    // R12 full duplex
    fork
      begin
        regWrite(0, 9'h05D);
        waitStart();
        sampleFrame(8, w, sOk, pOk);
      end
      begin
        repeat (3) @(negedge clk);
        driveRx(9'h0E4, 8, 1'b1);
      end
    join
    chk(w == 9'h05D, "R12 transmit during receive", w, 9'h05D);
    regRead(0, v);
    chk(rxFull == 1'b1 && v == 9'h0E4, "R12 receive during transmit", v, 9'h0E4);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule